// File: doc/BRIEF.md
# Selectable Binary/Decimal Timebase Scaler with Gated Frequency Output

The block turns a single base clock into a ladder of five timebase taps for the general counters of a timer subsystem. The taps come from a chain of four 4-bit digit stages, with one tap after each stage. A mode input sets whether every stage counts through sixteen states (binary ladder) or ten states (decimal ladder). With an 8 MHz base clock the decimal ladder gives 8 MHz, 800 kHz, 80 kHz, 8 kHz and 800 Hz. The binary ladder gives 8 MHz, 500 kHz, 31.25 kHz, about 1.95 kHz and about 122 Hz. The fastest tap is the base clock itself. Each tap appears as a one-cycle enable pulse in the base clock domain, so no derived clocks are created.

A frequency output pin is built on top of the ladder. A selector picks one tap as the source. A 4-bit programmable divider counts the source pulses and toggles the pin once every (divide value + 1) source pulses. A gate input stops the output and holds the pin low. The gate control sits in a three-state machine:
- FO_LOAD loads the divider and holds the pin low. It goes to FO_OFF if the gate input is set, and to FO_RUN otherwise.
- FO_RUN counts source pulses and drives the pin from the toggle level. It goes to FO_OFF when the gate input is set.
- FO_OFF holds the pin low and clears the level. It goes to FO_LOAD when the gate input clears.

The reset state is FO_LOAD, so the output is gated on after reset.

Top module: `fscale_timebase`

## Requirements
- R1: Out of reset, tap 0 (`tap_en[0]`) is high on every cycle; it stands for the undivided base clock.
- R2: In binary mode (`bcd_mode`=0), tap k+1 pulses for one cycle once every 16 pulses of tap k, so tap 1 recurs every 16 cycles and tap 2 every 256 cycles.
- R3: In decimal mode (`bcd_mode`=1), tap k+1 pulses once every 10 pulses of tap k, so tap 1 recurs every 10 cycles and tap 3 every 1000 cycles.
- R4: A higher tap is never high in a cycle where the tap below it is low.
- R5: In decimal mode, a stage that holds a value of 9 or more (left over from binary mode) produces a carry on its next enable and restarts from 0.
- R6: During reset the taps read 5'b00001 and the output pin is low; after reset all stages start at 0, so in binary mode the first tap-1 pulse comes in the 16th cycle after reset is released (cycle offset 15).
- R7: `fout_src` values 0 to 4 select taps 0 to 4 as the divider source; values 5 to 7 select tap 4.
- R8: In FO_RUN the pin toggles on the source pulse that finds the divider count at 0, and the count then reloads from `fout_div`. The pin therefore toggles once every `fout_div`+1 source pulses and rises only in the cycle after a source pulse.
- R9: While `fout_off` is 1, the pin is low from the cycle after the input is first seen.
- R10: When `fout_off` returns to 0, the block passes through FO_LOAD and restarts with the pin low. With the base clock as source and a divide value of d, the first rise comes d+3 cycles after the first cycle in which the gate input is low.
- R11: After reset with `fout_off`=0, source 0 and a divide value of 0, the pin first rises 2 cycles after reset is released.
- R12: A new `fout_div` value takes effect only when the divider next reloads, on a wrap or in FO_LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_mode | input | 1 | Stage radix select: 0 is binary (16), 1 is decimal (10) |
| fout_off | input | 1 | Frequency output gate: 1 stops the output and holds the pin low |
| fout_src | input | 3 | Tap selected as the divider source |
| fout_div | input | 4 | Divide value; the pin toggles every value+1 source pulses |
| tap_en | output | 5 | One-cycle enable pulses of taps 0 to 4 |
| fout | output | 1 | Gated frequency output pin |

## Verification
The tap-spacing properties assume that `bcd_mode` changes only between clock edges. A spacing is checked only across an interval in which the mode held still, so the irregular first gap after a mode switch is exempt. The bench changes the mode once, at a point where stage 0 holds 12, to exercise that gap on purpose. The output properties assume that `fout_off`, `fout_src` and `fout_div` are synchronous levels. The bench changes them only just after a rising edge, and it keeps `fout_off` low through reset so that the reset-to-first-rise timing can be checked.

// File: rtl/fscale_pkg.sv
package fscale_pkg;

    // Radix of one stage in decimal mode.
    localparam int DEC_RADIX = 10;

    // Frequency output gate controller states.
    typedef enum logic [1:0] {
        FO_LOAD = 2'd0,
        FO_RUN  = 2'd1,
        FO_OFF  = 2'd2
    } fout_state_e;

endpackage

// File: rtl/fscale_digit.sv
// One scaler stage: counts its enable pulses and passes a carry upward.
module fscale_digit
    import fscale_pkg::*;
#(
    parameter int DIGIT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bcd_mode,
    input  logic tick_in,
    output logic tick_out
);

    localparam logic [DIGIT_W-1:0] BIN_LAST = '1;
    localparam logic [DIGIT_W-1:0] DEC_LAST = DIGIT_W'(DEC_RADIX - 1);

    logic [DIGIT_W-1:0] val_q;
    logic               at_last;

    // A decimal stage treats any value of nine or above as its last state.
    always_comb begin
        if (bcd_mode) begin
            at_last = (val_q >= DEC_LAST);
        end else begin
            at_last = (val_q == BIN_LAST);
        end
    end

    assign tick_out = tick_in & at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (tick_in) begin
            val_q <= at_last ? '0 : val_q + 1'b1;
        end
    end

endmodule

// File: rtl/fscale_tapsel.sv
// Picks one tap as the divider source; out-of-range codes take the slowest tap.
module fscale_tapsel #(
    parameter int N_TAPS = 5,
    parameter int SRC_W  = $clog2(N_TAPS)
) (
    input  logic [N_TAPS-1:0] taps,
    input  logic [SRC_W-1:0]  src,
    output logic              tick
);

    localparam logic [SRC_W-1:0] TOP_IDX = SRC_W'(N_TAPS - 1);

    logic [SRC_W-1:0] idx;

    always_comb begin
        idx  = (src > TOP_IDX) ? TOP_IDX : src;
        tick = taps[idx];
    end

endmodule

// File: rtl/fscale_fout.sv
// Gated programmable divider driving the frequency output pin.
module fscale_fout
    import fscale_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_off,
    input  logic             tick,
    input  logic [DIV_W-1:0] div,
    output logic             pin
);

    fout_state_e      state_q;
    fout_state_e      state_d;
    logic [DIV_W-1:0] cnt_q;
    logic             lvl_q;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FO_LOAD: state_d = gate_off ? FO_OFF : FO_RUN;
            FO_RUN:  state_d = gate_off ? FO_OFF : FO_RUN;
            FO_OFF:  state_d = gate_off ? FO_OFF : FO_LOAD;
            default: state_d = FO_LOAD;
        endcase
    end

    // State register; reset leaves the output gated on.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FO_LOAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Divider count and toggle level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            unique case (state_q)
                FO_LOAD: begin
                    cnt_q <= div;
                    lvl_q <= 1'b0;
                end
                FO_RUN: begin
                    if (tick) begin
                        if (cnt_q == '0) begin
                            cnt_q <= div;
                            lvl_q <= ~lvl_q;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
                FO_OFF: begin
                    lvl_q <= 1'b0;
                end
                default: begin
                    cnt_q <= '0;
                    lvl_q <= 1'b0;
                end
            endcase
        end
    end

    // Output decode: the pin follows the level only while running.
    always_comb begin
        pin = (state_q == FO_RUN) && lvl_q;
    end

endmodule

// File: rtl/fscale_timebase.sv
// Top: stage chain, source selector and gated frequency output.
module fscale_timebase #(
    parameter int N_TAPS  = 5,
    parameter int DIGIT_W = 4,
    parameter int DIV_W   = 4,
    parameter int SRC_W   = $clog2(N_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bcd_mode,
    input  logic              fout_off,
    input  logic [SRC_W-1:0]  fout_src,
    input  logic [DIV_W-1:0]  fout_div,
    output logic [N_TAPS-1:0] tap_en,
    output logic              fout
);

    localparam int N_STAGES = N_TAPS - 1;

    logic [N_TAPS-1:0] taps;
    logic              src_tick;

    assign taps[0] = 1'b1;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
        fscale_digit #(
            .DIGIT_W (DIGIT_W)
        ) u_digit (
            .clk      (clk),
            .rst_n    (rst_n),
            .bcd_mode (bcd_mode),
            .tick_in  (taps[i]),
            .tick_out (taps[i+1])
        );
    end

    fscale_tapsel #(
        .N_TAPS (N_TAPS),
        .SRC_W  (SRC_W)
    ) u_tapsel (
        .taps (taps),
        .src  (fout_src),
        .tick (src_tick)
    );

    fscale_fout #(
        .DIV_W (DIV_W)
    ) u_fout (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_off (fout_off),
        .tick     (src_tick),
        .div      (fout_div),
        .pin      (fout)
    );

    assign tap_en = taps;

endmodule

// File: rtl/fscale_checks.sv
// Port-level properties of the timebase scaler, attached by bind.
module fscale_checks #(
    parameter int N_TAPS = 5,
    parameter int SRC_W  = $clog2(N_TAPS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bcd_mode,
    input logic              fout_off,
    input logic [SRC_W-1:0]  fout_src,
    input logic [N_TAPS-1:0] tap_en,
    input logic              fout
);

    localparam logic [SRC_W-1:0] TOP_IDX = SRC_W'(N_TAPS - 1);

    logic [7:0]       gap_q;
    logic             seen_q;
    logic             steady_q;
    logic             bcd_q;
    logic [SRC_W-1:0] sel_idx;
    logic             sel_now;

    always_comb begin
        sel_idx = (fout_src > TOP_IDX) ? TOP_IDX : fout_src;
        sel_now = tap_en[sel_idx];
    end

    // Cycles since the last tap-1 pulse, and whether the mode held still since then.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q    <= '0;
            seen_q   <= 1'b0;
            steady_q <= 1'b0;
            bcd_q    <= 1'b0;
        end else begin
            bcd_q <= bcd_mode;
            if (tap_en[1]) begin
                gap_q    <= 8'd1;
                seen_q   <= 1'b1;
                steady_q <= 1'b1;
            end else begin
                if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
                if (bcd_mode != bcd_q) steady_q <= 1'b0;
            end
        end
    end

    assert_bin_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_en[1] && seen_q && steady_q && !bcd_mode && !bcd_q) |-> (gap_q == 8'd16));

    assert_dec_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_en[1] && seen_q && steady_q && bcd_mode && bcd_q) |-> (gap_q == 8'd10));

    assert_rise_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fout) |-> $past(sel_now));

    assert_gated_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fout_off && $past(fout_off)) |-> !fout);

    assert_restart_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fout_off) |=> !fout);

endmodule

bind fscale_timebase fscale_checks #(
    .N_TAPS (N_TAPS),
    .SRC_W  (SRC_W)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .bcd_mode (bcd_mode),
    .fout_off (fout_off),
    .fout_src (fout_src),
    .tap_en   (tap_en),
    .fout     (fout)
);

// File: tb/test_fscale_timebase.sv
module test_fscale_timebase;

    localparam int CLK_PERIOD = 10;
    localparam int NT = 5;

    logic          clk      = 1'b0;
    logic          rst_n    = 1'b0;
    logic          bcd_mode = 1'b0;
    logic          fout_off = 1'b0;
    logic [2:0]    fout_src = 3'd0;
    logic [3:0]    fout_div = 4'd0;
    logic [NT-1:0] tap_en;
    logic          fout;

    always #(CLK_PERIOD/2) clk = ~clk;

    fscale_timebase i_fscale_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .bcd_mode (bcd_mode),
        .fout_off (fout_off),
        .fout_src (fout_src),
        .fout_div (fout_div),
        .tap_en   (tap_en),
        .fout     (fout)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    // Behavioural reference: stage values, output state (0 load, 1 run, 2 off).
    int m_dg [4] = '{0, 0, 0, 0};
    int m_st  = 0;
    int m_cnt = 0;
    bit m_lvl = 0;
    int cyc   = 0;

    // Measurements from the outputs.
    int lastp [NT] = '{0, 0, 0, 0, 0};
    int ival  [NT] = '{0, 0, 0, 0, 0};
    bit seen  [NT] = '{0, 0, 0, 0, 0};
    int first_f2 = -1;
    int last_rise = 0;
    int last_fall = 0;
    bit fout_prev = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [NT-1:0] model_taps();
        logic [NT-1:0] t;
        int radix;
        radix = bcd_mode ? 10 : 16;
        t[0] = 1'b1;
        for (int i = 0; i < NT-1; i++) t[i+1] = t[i] && (m_dg[i] >= radix - 1);
        return t;
    endfunction

    always @(posedge clk) begin
        logic [NT-1:0] t;
        int s;
        int radix;
        bit tick;
        if (!rst_n) begin
            for (int i = 0; i < NT-1; i++) m_dg[i] = 0;
            m_st = 0; m_cnt = 0; m_lvl = 0;
        end else begin
            t = model_taps();
            radix = bcd_mode ? 10 : 16;
            s = (fout_src > 3'd4) ? 4 : int'(fout_src);
            tick = t[s];
            case (m_st)
                0: begin m_cnt = fout_div; m_lvl = 0; m_st = fout_off ? 2 : 1; end
                1: begin
                    if (tick) begin
                        if (m_cnt == 0) begin m_cnt = fout_div; m_lvl = !m_lvl; end
                        else m_cnt = m_cnt - 1;
                    end
                    m_st = fout_off ? 2 : 1;
                end
                default: begin m_lvl = 0; m_st = fout_off ? 2 : 0; end
            endcase
            for (int i = 0; i < NT-1; i++)
                if (t[i]) m_dg[i] = (m_dg[i] >= radix - 1) ? 0 : m_dg[i] + 1;
        end
        cyc++;
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        logic [NT-1:0] exp_t;
        bit exp_f;
        if (rst_n && !done) begin
            exp_t = model_taps();
            exp_f = (m_st == 1) && m_lvl;
            chk(tap_en[0] == 1'b1, "R1", int'(tap_en[0]), 1);
            chk(tap_en == exp_t, bcd_mode ? "R3" : "R2", int'(tap_en), int'(exp_t));
            for (int k = 1; k < NT; k++)
                chk(!tap_en[k] || tap_en[k-1], "R4", int'(tap_en), int'(exp_t));
            chk(fout == exp_f, "R8", int'(fout), int'(exp_f));
            for (int k = 0; k < NT; k++) begin
                if (tap_en[k]) begin
                    if (seen[k]) ival[k] = cyc - lastp[k];
                    lastp[k] = cyc;
                    seen[k] = 1;
                end
            end
            if (tap_en[1] && first_f2 < 0) first_f2 = cyc;
            if (fout && !fout_prev) last_rise = cyc;
            if (!fout && fout_prev) last_fall = cyc;
            fout_prev = fout;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic int absdiff(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    initial begin
        int z;
        int p;
        int x;
        // Reset state.
        step(3);
        chk(tap_en == 5'b00001, "R6", int'(tap_en), 1);
        chk(fout == 1'b0, "R6", int'(fout), 0);
        rst_n = 1'b1;
        z = cyc;
        step(3);
        chk(last_rise == z + 2, "R11", last_rise - z, 2);

        // Binary ladder.
        step(600);
        chk(first_f2 == z + 15, "R6", first_f2 - z, 15);
        chk(ival[1] == 16, "R2", ival[1], 16);
        chk(ival[2] == 256, "R2", ival[2], 256);

        // Divider sourced from tap 1, divide value 2.
        fout_src = 3'd1;
        fout_div = 4'd2;
        step(300);
        chk(absdiff(last_rise, last_fall) == 48, "R7", absdiff(last_rise, last_fall), 48);

        // Switch to decimal while stage 0 holds 12.
        while (m_dg[0] != 12) step(1);
        bcd_mode = 1'b1;
        #1;
        chk(tap_en[1] == 1'b1, "R5", int'(tap_en[1]), 1);
        p = cyc;
        step(10);
        chk(cyc == p + 10 && tap_en[1] == 1'b1, "R5", int'(tap_en[1]), 1);
        step(2100);
        chk(ival[1] == 10, "R3", ival[1], 10);
        chk(ival[3] == 1000, "R3", ival[3], 1000);

        // Out-of-range source code picks tap 4; restart through the gate.
        fout_src = 3'd7;
        fout_div = 4'd0;
        fout_off = 1'b1;
        step(2);
        fout_off = 1'b0;
        step(21000);
        chk(absdiff(last_rise, last_fall) == 10000, "R7", absdiff(last_rise, last_fall), 10000);

        // Gate off: pin low from the following cycle.
        fout_src = 3'd0;
        fout_div = 4'd5;
        fout_off = 1'b1;
        for (int i = 1; i < 20; i++) begin
            step(1);
            chk(fout == 1'b0, "R9", int'(fout), 0);
        end

        // Restart, then change the divide value mid-count.
        fout_off = 1'b0;
        x = cyc;
        step(2);
        fout_div = 4'd1;
        step(10);
        chk(last_rise == x + 8, "R10", last_rise - x, 8);
        chk(last_fall - last_rise == 2, "R12", last_fall - last_rise, 2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule